// File: doc/BRIEF.md
# Fine-Phase DDS Edge Locator

This block is a direct digital synthesis core that finds where, inside one system clock period, the accumulator's most significant bit crosses its half-scale point. The tuning word is added to a main phase accumulator on every clock. Seven side lanes add fixed fractions k/8 of the tuning word (k = 1..7) to the same accumulator value, so together with the main accumulator the eight lanes sample the phase ramp at eight evenly spaced points inside each clock period.

Each lane's MSB is compared with its value one clock earlier. In the cycle where the main accumulator's MSB rises, the lanes that rose with it form a thermometer pattern that is anchored at the main lane. The pattern is converted into a 3-bit index that names one of eight equally spaced clock phases, and the index comes out with a one-cycle strobe. A downstream stage uses the index to pick the matching phase of a multi-phase clock. Index 0 means the crossing fell in the first eighth of the period, and index 7 means it fell in the last eighth. The coarse MSB of the main accumulator is also output. The tuning word must stay below half of full scale, so that there is at most one crossing per clock.

Top module: `fine_phase_dds`

## Requirements
- R1: After c clocks with reset low, `coarse_msb` equals bit ACC_W-1 of (c × N) mod 2^ACC_W, where N is the tuning word and the accumulator is 0 when reset is released.
- R2: `phase_valid` goes high exactly two clocks after `coarse_msb` rises and stays high for one cycle only. At all other times it is low.
- R3: With the strobe, `phase_index` equals the number of k in 1..7 for which A + floor(k × N / 8) < 2^(ACC_W-1). Here A is the accumulator value just before the update that raised `coarse_msb`. The lanes that rose in that cycle form a contiguous run that ends at the main lane.
- R4: When the accumulator lands exactly on half scale, only the main lane has risen, and the index is 7.
- R5: Lanes that cross half scale one clock after the main accumulator produce no strobe. The MSB falling at wraparound produces no strobe either.
- R6: A synchronous reset clears the accumulator, every lane and MSB history register, and the pipeline. `coarse_msb` and `phase_valid` read 0 after one reset clock, even if an event was in flight, and the sequence then restarts from 0.
- R7: A tuning word of 0 holds `coarse_msb` at 0 and never raises `phase_valid`.
- R8: The lane increments are registered copies of `tune_word` and its fractions. The first update after reset release uses the word that was present at the last reset clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tune_word | input | ACC_W | Tuning word N, below half of full scale |
| coarse_msb | output | 1 | MSB of the main phase accumulator |
| phase_index | output | 3 | Selected clock phase, 0 = earliest eighth |
| phase_valid | output | 1 | One-cycle strobe marking a new index |

## Verification
Two things can fall in the same cycle. The first pair is a pending strobe and a reset: the bench asserts reset while a crossing sits in the two-stage pipeline, then checks that the strobe that would have appeared is suppressed and that the restarted sequence matches the expected one. The second pair is the late lanes of one crossing and the next cycle of detection. With tuning words whose fraction splits a crossing across two clocks, such as 10000 and 20000, and with 32767, which crosses on every other clock, the bench checks the cycle after each strobe for silence and checks the index of every strobe against the formula in R3.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

    // Number of sampling lanes and phases; fixed by the 3-bit phase index.
    localparam int PHASES = 8;
    localparam int IDX_W  = $clog2(PHASES);

    typedef logic [PHASES-1:0] lane_vec_t;
    typedef logic [IDX_W-1:0]  phase_idx_t;

    // Converts the set of lanes that rose into a phase number.
    // More lanes rising means an earlier crossing, so the index is PHASES - count.
    function automatic phase_idx_t thermo_to_idx(input lane_vec_t rose);
        int unsigned cnt;
        cnt = 0;
        for (int i = 0; i < PHASES; i++) begin
            cnt += 32'(rose[i]);
        end
        if (cnt == 0) begin
            return '0;
        end
        return phase_idx_t'(PHASES - cnt);
    endfunction

endpackage

// File: rtl/fpd_step_gen.sv
module fpd_step_gen
    import fpd_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic                           clk,
    input  logic [ACC_W-1:0]               tune_word,
    output logic [PHASES-1:0][ACC_W-1:0]   inc_q
);

    localparam int PROD_W = ACC_W + IDX_W;

    typedef struct packed {
        logic [PHASES-1:0][ACC_W-1:0] inc;
    } step_state_t;

    step_state_t st_d, st_q;
    logic [ACC_W-1:0] frac_w [PHASES];

    // Lane g carries floor((g+1) * N / PHASES), built from shifted copies of N.
    for (genvar g = 0; g < PHASES; g++) begin : g_frac
        localparam int MULT = g + 1;
        logic [PROD_W-1:0] prod;
        always_comb begin
            prod = '0;
            for (int b = 0; b <= IDX_W; b++) begin
                if (((MULT >> b) & 1) == 1) begin
                    prod = prod + (PROD_W'(tune_word) << b);
                end
            end
        end
        assign frac_w[g] = prod[PROD_W-1:IDX_W];
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < PHASES; i++) begin
            st_d.inc[i] = frac_w[i];
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign inc_q = st_q.inc;

endmodule

// File: rtl/fpd_lanes.sv
module fpd_lanes
    import fpd_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [PHASES-1:0][ACC_W-1:0]   inc,
    output lane_vec_t                      rose,
    output logic                           coarse_msb
);

    localparam int TOP = PHASES - 1;

    typedef struct packed {
        logic [ACC_W-1:0]            acc;
        logic [TOP-1:0][ACC_W-1:0]   lane;
        lane_vec_t                   hist;
    } lane_state_t;

    lane_state_t st_d, st_q;
    lane_vec_t   msb_now;

    // The top lane is the accumulator itself; the others are taps on it.
    always_comb begin
        for (int i = 0; i < TOP; i++) begin
            msb_now[i] = st_q.lane[i][ACC_W-1];
        end
        msb_now[TOP] = st_q.acc[ACC_W-1];
    end

    always_comb begin
        st_d     = st_q;
        st_d.acc = st_q.acc + inc[TOP];
        for (int i = 0; i < TOP; i++) begin
            st_d.lane[i] = st_q.acc + inc[i];
        end
        st_d.hist = msb_now;
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rose       = msb_now & ~st_q.hist;
    assign coarse_msb = msb_now[TOP];

endmodule

// File: rtl/fpd_encode.sv
module fpd_encode
    import fpd_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  lane_vec_t   rose,
    output phase_idx_t  phase_index,
    output logic        phase_valid,
    output lane_vec_t   thermo_q
);

    typedef struct packed {
        lane_vec_t  thermo;
        phase_idx_t idx;
        logic       valid;
    } enc_state_t;

    enc_state_t st_d, st_q;

    // Stage 1 captures the rise pattern; stage 2 encodes it. Only a rise on the
    // main lane opens an event, so lanes that rise late are dropped.
    always_comb begin
        st_d        = st_q;
        st_d.thermo = rose;
        st_d.valid  = st_q.thermo[PHASES-1];
        if (st_q.thermo[PHASES-1]) begin
            st_d.idx = thermo_to_idx(st_q.thermo);
        end
        if (rst) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign phase_index = st_q.idx;
    assign phase_valid = st_q.valid;
    assign thermo_q    = st_q.thermo;

endmodule

// File: rtl/fine_phase_dds.sv
module fine_phase_dds
    import fpd_pkg::*;
#(
    parameter int ACC_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ACC_W-1:0]  tune_word,
    output logic              coarse_msb,
    output logic [2:0]        phase_index,
    output logic              phase_valid
);

    logic [PHASES-1:0][ACC_W-1:0] inc_w;
    lane_vec_t                    rose_w;
    lane_vec_t                    thermo_w;
    phase_idx_t                   idx_w;

    fpd_step_gen #(.ACC_W(ACC_W)) i_step (
        .clk       (clk),
        .tune_word (tune_word),
        .inc_q     (inc_w)
    );

    fpd_lanes #(.ACC_W(ACC_W)) i_lanes (
        .clk        (clk),
        .rst        (rst),
        .inc        (inc_w),
        .rose       (rose_w),
        .coarse_msb (coarse_msb)
    );

    fpd_encode i_enc (
        .clk         (clk),
        .rst         (rst),
        .rose        (rose_w),
        .phase_index (idx_w),
        .phase_valid (phase_valid),
        .thermo_q    (thermo_w)
    );

    assign phase_index = idx_w;

endmodule

// File: rtl/fpd_chk.sv
module fpd_chk
    import fpd_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      coarse_msb,
    input logic      phase_valid,
    input lane_vec_t thermo_q
);

    lane_vec_t inv;
    always_comb begin
        inv = ~thermo_q;
    end

    // R2
    rise_to_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(coarse_msb) |-> ##2 phase_valid);

    // R2
    strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
        phase_valid |=> !phase_valid);

    // R5
    strobe_source_chk: assert property (@(posedge clk) disable iff (rst)
        phase_valid |-> $past(coarse_msb, 2));

    // R3
    thermo_shape_chk: assert property (@(posedge clk) disable iff (rst)
        thermo_q[PHASES-1] |-> ((inv & (inv + lane_vec_t'(1))) == '0));

    // R6
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!phase_valid && !coarse_msb));

endmodule

bind fine_phase_dds fpd_chk i_fpd_chk (
    .clk         (clk),
    .rst         (rst),
    .coarse_msb  (coarse_msb),
    .phase_valid (phase_valid),
    .thermo_q    (thermo_w)
);

// File: tb/test_fine_phase_dds.sv
module test_fine_phase_dds;

    localparam time CLK_PERIOD = 10ns;
    localparam int  TRACE      = 300;
    localparam longint FULL    = 65536;
    localparam longint HALF    = 32768;

    typedef struct packed {
        logic [15:0] n;
        logic [7:0]  first_c;
        logic [2:0]  idx;
    } vec_t;

    // tuning word, cycle of first strobe after release, index of that strobe
    localparam vec_t VEC [8] = '{
        '{16'd5000,  8'd9,  3'd4},
        '{16'd4096,  8'd10, 3'd7},
        '{16'd6000,  8'd8,  3'd3},
        '{16'd16000, 8'd5,  3'd0},
        '{16'd32767, 8'd4,  3'd0},
        '{16'd10000, 8'd6,  3'd2},
        '{16'd7000,  8'd7,  3'd5},
        '{16'd20000, 8'd4,  3'd5}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] tune = '0;
    logic        coarse_msb;
    logic [2:0]  phase_index;
    logic        phase_valid;
    int          checks = 0;
    int          errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fine_phase_dds #(.ACC_W(16)) i_fine_phase_dds (
        .clk         (clk),
        .rst         (rst),
        .tune_word   (tune),
        .coarse_msb  (coarse_msb),
        .phase_index (phase_index),
        .phase_valid (phase_valid)
    );

    function automatic int m_msb(input longint c, input longint n);
        return (((c * n) % FULL) >= HALF) ? 1 : 0;
    endfunction

    function automatic int m_valid(input longint c, input longint n);
        if (c < 3) return 0;
        return (m_msb(c - 2, n) == 1 && m_msb(c - 3, n) == 0) ? 1 : 0;
    endfunction

    function automatic int m_idx(input longint c, input longint n);
        longint a;
        int cnt;
        a = ((c - 3) * n) % FULL;
        cnt = 0;
        for (int k = 1; k < 8; k++) begin
            if (a + (k * n) / 8 < HALF) cnt++;
        end
        return cnt;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input longint n);
        @(negedge clk);
        rst  = 1'b1;
        tune = 16'(n);
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R6 coarse_msb in reset", int'(coarse_msb), 0);
        chk("R6 phase_valid in reset", int'(phase_valid), 0);
    endtask

    // Starts at c = 0 (no clock since release) and walks the model cycle by cycle.
    task automatic trace(input longint n, input int cycles, output int first_c, output int first_idx);
        first_c   = 0;
        first_idx = 0;
        for (int c = 1; c <= cycles; c++) begin
            @(negedge clk);
            chk("R1 coarse_msb", int'(coarse_msb), m_msb(c, n));
            chk("R2 R5 phase_valid", int'(phase_valid), m_valid(c, n));
            if (phase_valid && m_valid(c, n) == 1) begin
                chk("R3 phase_index", int'(phase_index), m_idx(c, n));
            end
            if (phase_valid && first_c == 0) begin
                first_c   = c;
                first_idx = int'(phase_index);
            end
        end
    endtask

    initial begin
        int fc, fi;
        // Table-driven sweep
        for (int v = 0; v < 8; v++) begin
            do_reset(longint'(VEC[v].n));
            trace(longint'(VEC[v].n), TRACE, fc, fi);
            chk("R8 first strobe cycle", fc, int'(VEC[v].first_c));
            if (VEC[v].n == 16'd4096)
                chk("R4 exact half-scale index", fi, int'(VEC[v].idx));
            else
                chk("R3 first strobe index", fi, int'(VEC[v].idx));
        end

        // R5: crossing split across two clocks; late lanes must stay silent
        do_reset(10000);
        repeat (6) @(negedge clk);
        chk("R3 split crossing index", int'(phase_index), 2);
        @(negedge clk);
        chk("R5 late lanes no strobe", int'(phase_valid), 0);

        // R6: reset while an event is in the pipeline
        do_reset(7000);
        repeat (6) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R6 pending strobe cleared", int'(phase_valid), 0);
        chk("R6 accumulator cleared", int'(coarse_msb), 0);
        rst = 1'b0;
        trace(7000, 40, fc, fi);
        chk("R6 restart first strobe cycle", fc, 7);
        chk("R6 restart first index", fi, 5);

        // R7: zero tuning word
        do_reset(0);
        trace(0, 100, fc, fi);
        chk("R7 no strobe with zero word", fc, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule